// File: doc/BRIEF.md
# Multi-Channel Reloading Periodic Timer Array

The block holds eleven independent 24-bit down-counters. Each channel has a start (load) value, a run bit and a live count. While it runs, a channel counts down once per clock. When it reaches zero it fires and reloads its start value, so a load value of N gives a period of N+1 clocks. A register bus gives access to the start value, the control bits and the current count of every channel.

The channels have fixed roles. Channel 0 is a real-time wake-up timer, and channels 1 to 4 are general interrupt timers. These five set sticky flags that are cleared by writing 1, and each flag is gated by a per-channel interrupt enable onto the wake and interrupt lines. Channels 5 to 8 drive one-cycle DMA request pulses and channels 9 and 10 drive one-cycle converter start pulses. The trigger channels hold no sticky state.

Top module: `pit_array`

## Requirements
- R1: After reset, every control, load and count register reads 0, the flag register reads 0, and wake_o, irq_o, dma_trig_o and adc_trig_o are low.
- R2: A channel with load value N that is started by a run write at clock edge E0 fires first N+1 cycles after E0, and then every N+1 cycles while it runs.
- R3: A running channel's count decrements by one per clock. The count register returns the live value at any time.
- R4: A load write to a stopped channel changes only the stored start value, which the count picks up when the channel starts. A load write to a running channel does not disturb the countdown in progress and is used at the next reload.
- R5: Writing run=0 freezes the count (the edge of the write still decrements it). Writing run=1 to a stopped channel loads the count from the start value.
- R6: On expiry, each interrupt channel (0 to 4) sets flag bit <channel> in the flag register. The flag stays set until a write to the flag register has a 1 in that bit. Writing 0 to a bit leaves it unchanged.
- R7: wake_o is flag bit 0 AND the ie bit of channel 0. irq_o is the OR, over channels 1 to 4, of flag AND ie.
- R8: Trigger channels (5 to 8 drive dma_trig_o[ch-5], 9 and 10 drive adc_trig_o[ch-9]) emit a one-cycle pulse per expiry when load is not 0. They set no flag, flag register bits 5 and above read 0, and their ie bit reads 0.
- R9: The address is {channel[3:0], sel[1:0]}. sel 0 is control (bit0 run, bit1 ie), sel 1 is the load value (bits 23:0), and sel 2 is the count, which is read-only so writes to it are ignored. Channel field 15 with sel 0 is the flag register. Any other address reads 0.
- R10: A load value of 0 makes a running trigger channel pulse on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Register address {channel, sel} |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| wake_o | output | 1 | Wake-up request from channel 0 |
| irq_o | output | 1 | Combined interrupt from channels 1 to 4 |
| dma_trig_o | output | 4 | DMA request pulses from channels 5 to 8 |
| adc_trig_o | output | 2 | Converter start pulses from channels 9 and 10 |

## Verification
On every cycle, the assertions check the following:
- a running channel decrements or reloads;
- a stopped channel holds its count;
- a start loads the start value;
- a pulse after a non-zero reload is followed by a gap;
- flags keep their value unless they are cleared.

Only the bench scenarios can show the cycle-exact first-expiry latency and the period of each channel. The same holds for the deferred use of a load written while running, the role split between flag and pulse channels, and the address decode with its read-only and unmapped locations.

// File: rtl/pit_array_pkg.sv
package pit_array_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_LOAD  = 2'd1,
    SEL_COUNT = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_IE_BIT  = 1;
endpackage

// File: rtl/pit_channel.sv
module pit_channel #(
  parameter int CNT_W  = 24,
  parameter bit HAS_IE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             run_wr_i,
  input  logic             ie_wr_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_wr_i,
  output logic             run_o,
  output logic             ie_o,
  output logic [CNT_W-1:0] load_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o,
  output logic             pulse_o
);
  logic             run_q, pulse_q, ie_q, start;
  logic [CNT_W-1:0] load_q, cnt_q;

  assign start    = ctrl_we_i && run_wr_i && !run_q;
  assign expire_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else if (ctrl_we_i) run_q <= run_wr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_q <= '0;
    else if (load_we_i) load_q <= load_wr_i;
  end

  // start and reload both take the stored start value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (start)    cnt_q <= load_q;
    else if (expire_o) cnt_q <= load_q;
    else if (run_q)    cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else pulse_q <= expire_o;
  end

  generate
    if (HAS_IE) begin : g_ie
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ie_q <= 1'b0;
        else if (ctrl_we_i) ie_q <= ie_wr_i;
      end
    end else begin : g_no_ie
      logic unused_ie;
      assign unused_ie = ie_wr_i;
      assign ie_q = 1'b0;
    end
  endgenerate

  assign run_o   = run_q;
  assign ie_o    = ie_q;
  assign load_o  = load_q;
  assign cnt_o   = cnt_q;
  assign pulse_o = pulse_q;

  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == $past(load_q))); // R2
  AST_DECR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !start) |=> $stable(cnt_q)); // R5
  AST_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (cnt_q == $past(load_q))); // R5
  AST_PULSE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q && cnt_q != '0) |=> !pulse_q); // R8
endmodule

// File: rtl/pit_flags.sv
module pit_flags #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q, clr;

  assign clr = clr_we_i ? clr_mask_i : '0;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else flag_q <= (flag_q & ~clr) | set_i;
  end

  assign flag_o = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flag_q & ~clr)) |=> ((flag_q & $past(flag_q & ~clr)) == $past(flag_q & ~clr))); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr & ~set_i)) |=> ((flag_q & $past(clr & ~set_i)) == '0)); // R6
endmodule

// File: rtl/pit_bus.sv
module pit_bus
  import pit_array_pkg::*;
#(
  parameter int N_CH   = 11,
  parameter int N_INT  = 5,
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [N_CH-1:0]            run_i,
  input  logic [N_CH-1:0]            ie_i,
  input  logic [N_CH-1:0][CNT_W-1:0] load_i,
  input  logic [N_CH-1:0][CNT_W-1:0] cnt_i,
  input  logic [N_INT-1:0]           flag_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [N_CH-1:0]            ctrl_we_o,
  output logic [N_CH-1:0]            load_we_o,
  output logic                       flag_we_o
);
  localparam int CH_AW = ADDR_W - 2;

  logic [CH_AW-1:0] ch_idx;
  reg_sel_e         sel;

  assign ch_idx = addr_i[ADDR_W-1:2];
  assign sel    = reg_sel_e'(addr_i[1:0]);

  always_comb begin
    ctrl_we_o = '0;
    load_we_o = '0;
    flag_we_o = 1'b0;
    rdata_o   = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (ch_idx == CH_AW'(i)) begin
        unique case (sel)
          SEL_CTRL: begin
            ctrl_we_o[i] = we_i;
            rdata_o      = DATA_W'({ie_i[i], run_i[i]});
          end
          SEL_LOAD: begin
            load_we_o[i] = we_i;
            rdata_o      = DATA_W'(load_i[i]);
          end
          SEL_COUNT: rdata_o = DATA_W'(cnt_i[i]);
          default:   rdata_o = '0;
        endcase
      end
    end
    if (ch_idx == '1 && sel == SEL_CTRL) begin
      flag_we_o = we_i;
      rdata_o   = DATA_W'(flag_i);
    end
  end
endmodule

// File: rtl/pit_array.sv
module pit_array
  import pit_array_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int N_IRQ  = 4,
  parameter int N_DMA  = 4,
  parameter int N_ADC  = 2,
  parameter int DATA_W = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           bus_we_i,
  input  logic [$clog2(2+N_IRQ+N_DMA+N_ADC)+1:0] bus_addr_i,
  input  logic [DATA_W-1:0]              bus_wdata_i,
  output logic [DATA_W-1:0]              bus_rdata_o,
  output logic                           wake_o,
  output logic                           irq_o,
  output logic [N_DMA-1:0]               dma_trig_o,
  output logic [N_ADC-1:0]               adc_trig_o
);
  localparam int N_INT  = 1 + N_IRQ;
  localparam int N_CH   = N_INT + N_DMA + N_ADC;
  localparam int CH_AW  = $clog2(N_CH + 1);
  localparam int ADDR_W = CH_AW + 2;
  localparam int DMA_LO = N_INT;
  localparam int ADC_LO = N_INT + N_DMA;

  logic [N_CH-1:0]            run, ie, expire, pulse, ctrl_we, load_we;
  logic [N_CH-1:0][CNT_W-1:0] load_v, cnt_v;
  logic [N_INT-1:0]           flag;
  logic                       flag_we;
  logic                       unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DATA_W-1:CNT_W];

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
      pit_channel #(
        .CNT_W (CNT_W),
        .HAS_IE(i < N_INT)
      ) u_ch (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ctrl_we_i(ctrl_we[i]),
        .run_wr_i (bus_wdata_i[CTRL_RUN_BIT]),
        .ie_wr_i  (bus_wdata_i[CTRL_IE_BIT]),
        .load_we_i(load_we[i]),
        .load_wr_i(bus_wdata_i[CNT_W-1:0]),
        .run_o    (run[i]),
        .ie_o     (ie[i]),
        .load_o   (load_v[i]),
        .cnt_o    (cnt_v[i]),
        .expire_o (expire[i]),
        .pulse_o  (pulse[i])
      );
    end
  endgenerate

  pit_flags #(.N(N_INT)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (expire[N_INT-1:0]),
    .clr_we_i  (flag_we),
    .clr_mask_i(bus_wdata_i[N_INT-1:0]),
    .flag_o    (flag)
  );

  pit_bus #(
    .N_CH  (N_CH),
    .N_INT (N_INT),
    .CNT_W (CNT_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_bus (
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .run_i    (run),
    .ie_i     (ie),
    .load_i   (load_v),
    .cnt_i    (cnt_v),
    .flag_i   (flag),
    .rdata_o  (bus_rdata_o),
    .ctrl_we_o(ctrl_we),
    .load_we_o(load_we),
    .flag_we_o(flag_we)
  );

  assign wake_o     = flag[0] & ie[0];
  assign irq_o      = |(flag[N_INT-1:1] & ie[N_INT-1:1]);
  assign dma_trig_o = pulse[DMA_LO +: N_DMA];
  assign adc_trig_o = pulse[ADC_LO +: N_ADC];
endmodule

// File: tb/pit_array_test.sv
module pit_array_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wake, irq;
  logic [3:0]  dma;
  logic [1:0]  adc;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  localparam logic [5:0] FLAG_A = 6'h3C;
  localparam int N_VEC = 5;
  // channel, load value, expected period
  localparam int VEC [N_VEC][3] = '{'{5, 3, 4}, '{6, 10, 11}, '{8, 1, 2},
                                    '{9, 20, 21}, '{10, 0, 1}};

  pit_array uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bus_we_i   (we),
    .bus_addr_i (addr),
    .bus_wdata_i(wdata),
    .bus_rdata_o(rdata),
    .wake_o     (wake),
    .irq_o      (irq),
    .dma_trig_o (dma),
    .adc_trig_o (adc)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic logic [5:0] ra(int ch, int sel);
    return {4'(ch), 2'(sel)};
  endfunction

  function automatic logic sig(int ch);
    if (ch >= 5 && ch <= 8) return dma[ch-5];
    if (ch >= 9 && ch <= 10) return adc[ch-9];
    return 1'b0;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wait_pulse(int ch, output int stamp);
    stamp = -1;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (sig(ch)) begin
        stamp = cyc;
        break;
      end
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, y;
    int c0, p1, p2, p3;
    bit all_zero;

    repeat (3) @(negedge clk);
    // R1 reset state
    all_zero = 1'b1;
    for (int ch = 0; ch < 11; ch++) begin
      for (int s = 0; s < 3; s++) begin
        rd(ra(ch, s), v);
        if (v != 0) all_zero = 1'b0;
      end
    end
    rd(FLAG_A, v);
    check(all_zero && v == 0, "R1 regs", v, 0);
    check({wake, irq, dma, adc} == 0, "R1 outputs", {wake, irq, dma, adc}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(FLAG_A, v);
    check(v == 0 && {wake, irq, dma, adc} == 0, "R1 after release", v, 0);

    // R2 / R10 vector walk over trigger channels
    for (int n = 0; n < N_VEC; n++) begin
      wr(ra(VEC[n][0], 1), 32'(VEC[n][1]));
      wr(ra(VEC[n][0], 0), 32'h1);
      c0 = cyc;
      wait_pulse(VEC[n][0], p1);
      check(p1 - c0 == VEC[n][2], "R2 first expiry", p1 - c0, VEC[n][2]);
      wait_pulse(VEC[n][0], p2);
      check(p2 - p1 == VEC[n][2], "R2 period", p2 - p1, VEC[n][2]);
      wr(ra(VEC[n][0], 0), 32'h0);
    end

    // R3 live count
    wr(ra(2, 1), 32'd100);
    wr(ra(2, 0), 32'h1);
    repeat (10) @(negedge clk);
    rd(ra(2, 2), v);
    check(v == 90, "R3 live count", v, 90);
    repeat (5) @(negedge clk);
    rd(ra(2, 2), v);
    check(v == 85, "R3 live count later", v, 85);

    // R5 freeze and restart
    wr(ra(2, 0), 32'h0);
    rd(ra(2, 2), y);
    check(y == 83, "R5 count at stop", y, 83);
    repeat (20) @(negedge clk);
    rd(ra(2, 2), v);
    check(v == y, "R5 frozen", v, y);
    wr(ra(2, 0), 32'h1);
    rd(ra(2, 2), v);
    check(v == 100, "R5 restart reload", v, 100);
    wr(ra(2, 0), 32'h0);

    // R4 load while stopped
    rd(ra(2, 2), y);
    wr(ra(2, 1), 32'd7);
    rd(ra(2, 2), v);
    check(v == y, "R4 stopped load not applied", v, y);
    wr(ra(2, 0), 32'h1);
    rd(ra(2, 2), v);
    check(v == 7, "R4 load on start", v, 7);
    wr(ra(2, 0), 32'h0);

    // R4 load while running
    wr(ra(5, 1), 32'd7);
    wr(ra(5, 0), 32'h1);
    wait_pulse(5, p1);
    wr(ra(5, 1), 32'd3);
    wait_pulse(5, p2);
    check(p2 - p1 == 8, "R4 current period kept", p2 - p1, 8);
    wait_pulse(5, p3);
    check(p3 - p2 == 4, "R4 new period at reload", p3 - p2, 4);
    wr(ra(5, 0), 32'h0);

    // R6 / R7 interrupt channel 1
    wr(ra(1, 1), 32'd4);
    wr(ra(1, 0), 32'h1);
    repeat (6) @(negedge clk);
    rd(FLAG_A, v);
    check(v == 32'h2, "R6 flag set", v, 2);
    check(irq == 1'b0, "R7 irq masked", irq, 0);
    wr(ra(1, 0), 32'h0);
    wr(ra(1, 0), 32'h2);
    check(irq == 1'b1, "R7 irq enabled", irq, 1);
    wr(FLAG_A, 32'h0);
    rd(FLAG_A, v);
    check(v == 32'h2, "R6 write 0 keeps flag", v, 2);
    wr(FLAG_A, 32'h2);
    rd(FLAG_A, v);
    check(v == 0, "R6 write 1 clears", v, 0);
    check(irq == 1'b0, "R7 irq after clear", irq, 0);

    // R7 wake channel 0
    wr(ra(0, 1), 32'd2);
    wr(ra(0, 0), 32'h3);
    repeat (4) @(negedge clk);
    check(wake == 1'b1, "R7 wake", wake, 1);
    check(irq == 1'b0, "R7 wake not on irq", irq, 0);
    wr(ra(0, 0), 32'h2);
    wr(FLAG_A, 32'h1);
    check(wake == 1'b0, "R7 wake cleared", wake, 0);

    // R8 trigger channel behaviour
    wr(ra(9, 1), 32'd5);
    wr(ra(9, 0), 32'h3);
    rd(ra(9, 0), v);
    check(v == 32'h1, "R8 ie reads 0 on trigger", v, 1);
    wait_pulse(9, p1);
    @(negedge clk);
    check(adc[0] == 1'b0, "R8 one-cycle pulse", adc[0], 0);
    rd(FLAG_A, v);
    check(v == 0, "R8 no flag", v, 0);
    check(irq == 1'b0 && wake == 1'b0, "R8 no interrupt", {wake, irq}, 0);
    wr(ra(9, 0), 32'h0);

    // R9 read-only count and unmapped space
    rd(ra(2, 2), y);
    wr(ra(2, 2), 32'h123);
    rd(ra(2, 2), v);
    check(v == y, "R9 count write ignored", v, y);
    rd(ra(2, 1), v);
    check(v == 7, "R9 load readback", v, 7);
    rd(ra(12, 0), v);
    check(v == 0, "R9 unmapped", v, 0);
    rd(ra(3, 3), v);
    check(v == 0, "R9 unused sel", v, 0);

    // R10 load 0 pulses every cycle
    wr(ra(6, 1), 32'd0);
    wr(ra(6, 0), 32'h1);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(dma[1] == 1'b1, "R10 continuous pulse", dma[1], 1);
    end
    wr(ra(6, 0), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule